// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Unit

This block keeps a small set of peripheral interrupt sources, a matching set of enable bits and one global enable bit. Peripherals raise single-cycle request pulses that latch into the pending flags. The CPU reads and writes the flag and enable registers through a plain register port, and raises or drops the global enable with two command pins.

At every instruction boundary the CPU pulses `step_i` and presents its current program counter and stack pointer. Suppose the global enable is on and at least one flag is both pending and enabled. The block then accepts the boundary by raising `take_o` in that same cycle, and the CPU stalls. The lowest-numbered pending and enabled source wins. Its flag and the global enable are cleared. The return address goes out as two byte writes on a valid/ready stack port, high byte first. One cycle after the second write is accepted, `done_o` pulses and carries the new program counter (the winner's vector) and the new stack pointer.

The stack port follows the usual valid/ready rules. Once `stk_valid_o` is raised, it stays high, and address and data stay unchanged, until a cycle in which `stk_ready_i` is high. A write is transferred in the cycle where both are high. The sink may hold `stk_ready_i` low for any number of cycles.

Top module: `irq_dispatch_unit`

## Requirements
- R1: After reset all pending flags, all enable bits and the global enable are 0. `stk_valid_o`, `done_o`, `busy_o` and `take_o` are low. The flag register reads 0xE0 and the enable register reads 0x00.
- R2: A write to address 0xFF0F loads the five pending flags from data bits 4..0, and a read there returns the flags in bits 4..0 with bits 7..5 reading 1. Address 0xFFFF holds the enable bits in bits 4..0, and its bits 7..5 read 0. Any other address reads 0x00.
- R3: A high bit k of `irq_req_i` sets pending flag k at the next edge. It is not lost when a dispatch clears a different flag in the same cycle, and it is ORed on top of a CPU flag write in the same cycle.
- R4: `ime_set_i` turns the global enable on and `ime_clr_i` turns it off. If both are high, off wins. The state shows on `ime_o` one cycle later.
- R5: A boundary pulse on `step_i` is taken only when the global enable is on and flags AND enables is nonzero. Otherwise `take_o` stays low, no stack write or done pulse follows, and the flags keep their value.
- R6: The lowest-numbered pending and enabled source wins. Its vector is 0x0040 + 8 × its index (0x0040, 0x0048, 0x0050, 0x0058, 0x0060).
- R7: A taken dispatch clears the global enable and the winning flag at the next edge. Other pending flags are kept.
- R8: The first stack write puts PC[15:8] at SP−1 and the second puts PC[7:0] at SP−2. Both use the PC and SP captured at the boundary pulse.
- R9: While `stk_valid_o` is high and `stk_ready_i` is low, `stk_valid_o`, `stk_addr_o` and `stk_data_o` hold steady.
- R10: `done_o` is high for exactly one cycle, the cycle after the second write is accepted. In that cycle `pc_o` is the vector and `sp_o` is SP−2. Boundary pulses while `busy_o` is high are not taken.
- R11: Stack addresses wrap modulo 2^16. With SP = 0x0001 the writes go to 0x0000 and 0xFFFF, and `sp_o` is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 5 | Peripheral request pulses, one per source |
| cpu_addr_i | input | 16 | Register port address |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_wdata_i | input | 8 | Register write data |
| cpu_rdata_o | output | 8 | Register read data (combinational from address) |
| ime_set_i | input | 1 | Turn global enable on |
| ime_clr_i | input | 1 | Turn global enable off |
| ime_o | output | 1 | Current global enable |
| step_i | input | 1 | Instruction-boundary pulse |
| pc_i | input | 16 | Program counter at the boundary |
| sp_i | input | 16 | Stack pointer at the boundary |
| take_o | output | 1 | Boundary accepted for dispatch (same cycle) |
| busy_o | output | 1 | Dispatch sequence in progress |
| stk_valid_o | output | 1 | Stack write valid |
| stk_ready_i | input | 1 | Stack write ready |
| stk_addr_o | output | 16 | Stack write address |
| stk_data_o | output | 8 | Stack write byte |
| done_o | output | 1 | One-cycle pulse: load PC and SP |
| pc_o | output | 16 | New program counter, valid with done_o |
| sp_o | output | 16 | New stack pointer, valid with done_o |

## Verification
`take_o` and `cpu_rdata_o` are combinational, so the bench samples them just after driving its inputs at the falling edge. Flag, enable and global-enable effects appear one edge later. With ready held high, the high-byte write is presented one cycle after the boundary pulse, the low-byte write a cycle after that, and `done_o` in the third cycle. Each stalled cycle of `stk_ready_i` pushes everything after it back by one cycle. The bench drives at the falling edge and advances by whole cycles. It compares against these counts, rechecks the held write on every stalled cycle, and reads the flags back afterwards.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PUSH_HI = 2'd1,
    ST_PUSH_LO = 2'd2,
    ST_DONE    = 2'd3
  } disp_state_e;

endpackage

// File: rtl/irqd_regs.sv
module irqd_regs #(
  parameter int N_SRC = 5,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F,
  parameter logic [ADDR_W-1:0] EN_ADDR = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  req_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              ime_set_i,
  input  logic              ime_clr_i,
  input  logic              take_i,
  input  logic [N_SRC-1:0]  take_mask_i,
  output logic [N_SRC-1:0]  flag_o,
  output logic [N_SRC-1:0]  en_o,
  output logic              ime_o
);
  localparam int PAD_W = DATA_W - N_SRC;

  logic [N_SRC-1:0] flag_q, en_q;
  logic             ime_q;
  logic             flag_wr, en_wr;
  logic [N_SRC-1:0] flag_base;

  assign flag_wr = cpu_wr_i && (cpu_addr_i == FLAG_ADDR);
  assign en_wr   = cpu_wr_i && (cpu_addr_i == EN_ADDR);

  // CPU write replaces the flags; otherwise a dispatch clears its winner.
  // New requests are always ORed on top so none is dropped.
  always_comb begin
    if (flag_wr)     flag_base = cpu_wdata_i[N_SRC-1:0];
    else if (take_i) flag_base = flag_q & ~take_mask_i;
    else             flag_base = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      ime_q  <= 1'b0;
    end else begin
      flag_q <= flag_base | req_i;
      if (en_wr) en_q <= cpu_wdata_i[N_SRC-1:0];
      if (ime_clr_i || take_i) ime_q <= 1'b0;
      else if (ime_set_i)      ime_q <= 1'b1;
    end
  end

  always_comb begin
    if (cpu_addr_i == FLAG_ADDR)    cpu_rdata_o = {{PAD_W{1'b1}}, flag_q};
    else if (cpu_addr_i == EN_ADDR) cpu_rdata_o = {{PAD_W{1'b0}}, en_q};
    else                            cpu_rdata_o = '0;
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign ime_o  = ime_q;

  assert_req_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) && !flag_wr |=> ((flag_q & $past(req_i)) == $past(req_i)));

  assert_winner_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !flag_wr && ((req_i & take_mask_i) == '0)
      |=> ((flag_q & $past(take_mask_i)) == '0));

  assert_ime_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !ime_q);

  assert_ime_raised_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ime_set_i && !ime_clr_i && !take_i |=> ime_q);

endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter #(
  parameter int N_SRC = 5,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0040,
  parameter int VEC_STEP = 8
) (
  input  logic [N_SRC-1:0]  pend_i,
  output logic [N_SRC-1:0]  grant_o,
  output logic              any_o,
  output logic [ADDR_W-1:0] vec_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC:0]   seen;
  logic [IDX_W-1:0] idx;

  assign seen[0] = 1'b0;

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_pri
    assign grant_o[gi]  = pend_i[gi] & ~seen[gi];
    assign seen[gi + 1] = seen[gi] | pend_i[gi];
  end

  assign any_o = seen[N_SRC];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (grant_o[i]) idx = IDX_W'(i);
    end
  end

  assign vec_o = VEC_BASE + ADDR_W'(VEC_STEP) * ADDR_W'(idx);

endmodule

// File: rtl/irqd_seq.sv
module irqd_seq
  import irqd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] vec_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              stk_valid_o,
  input  logic              stk_ready_i,
  output logic [ADDR_W-1:0] stk_addr_o,
  output logic [DATA_W-1:0] stk_data_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  disp_state_e      state_q;
  logic [ADDR_W-1:0] ret_q, sp_q, vec_q;

  assign take_o = step_i && hit_i && (state_q == ST_IDLE);
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= '0;
      sp_q    <= '0;
      vec_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (take_o) begin
          ret_q   <= pc_i;
          sp_q    <= sp_i;
          vec_q   <= vec_i;
          state_q <= ST_PUSH_HI;
        end
        ST_PUSH_HI: if (stk_ready_i) state_q <= ST_PUSH_LO;
        ST_PUSH_LO: if (stk_ready_i) state_q <= ST_DONE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stk_valid_o = 1'b0;
    stk_addr_o  = '0;
    stk_data_o  = '0;
    if (state_q == ST_PUSH_HI) begin
      stk_valid_o = 1'b1;
      stk_addr_o  = sp_q - ONE;
      stk_data_o  = ret_q[ADDR_W-1 -: DATA_W];
    end else if (state_q == ST_PUSH_LO) begin
      stk_valid_o = 1'b1;
      stk_addr_o  = sp_q - TWO;
      stk_data_o  = ret_q[DATA_W-1:0];
    end
  end

  assign done_o = (state_q == ST_DONE);
  assign pc_o   = vec_q;
  assign sp_o   = sp_q - TWO;

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_valid_o && !stk_ready_i
      |=> stk_valid_o && $stable(stk_addr_o) && $stable(stk_data_o));

  assert_low_follows_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH_HI) && stk_ready_i
      |=> stk_valid_o && (stk_addr_o == $past(stk_addr_o) - ONE));

  assert_done_after_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH_LO) && stk_ready_i |=> done_o);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/irq_dispatch_unit.sv
module irq_dispatch_unit #(
  parameter int N_SRC = 5,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F,
  parameter logic [ADDR_W-1:0] EN_ADDR = 16'hFFFF,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0040,
  parameter int VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              ime_set_i,
  input  logic              ime_clr_i,
  output logic              ime_o,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              stk_valid_o,
  input  logic              stk_ready_i,
  output logic [ADDR_W-1:0] stk_addr_o,
  output logic [DATA_W-1:0] stk_data_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o
);
  logic [N_SRC-1:0]  flag, en, pend, grant;
  logic              any_pend, hit;
  logic [ADDR_W-1:0] vec;

  irqd_regs #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .req_i(irq_req_i),
    .cpu_addr_i(cpu_addr_i), .cpu_wr_i(cpu_wr_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
    .ime_set_i(ime_set_i), .ime_clr_i(ime_clr_i),
    .take_i(take_o), .take_mask_i(grant),
    .flag_o(flag), .en_o(en), .ime_o(ime_o)
  );

  assign pend = flag & en;

  irqd_arbiter #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_arb (
    .pend_i(pend), .grant_o(grant), .any_o(any_pend), .vec_o(vec)
  );

  assign hit = ime_o && any_pend;

  irqd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .hit_i(hit),
    .vec_i(vec), .pc_i(pc_i), .sp_i(sp_i),
    .take_o(take_o), .busy_o(busy_o),
    .stk_valid_o(stk_valid_o), .stk_ready_i(stk_ready_i),
    .stk_addr_o(stk_addr_o), .stk_data_o(stk_data_o),
    .done_o(done_o), .pc_o(pc_o), .sp_o(sp_o)
  );

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !take_o);

endmodule

// File: tb/sim_irq_dispatch_unit.sv
module sim_irq_dispatch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  irq_req = '0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        ime_set = 1'b0, ime_clr = 1'b0, ime;
  logic        step = 1'b0;
  logic [15:0] pc_in = '0, sp_in = '0;
  logic        take, busy, stk_valid;
  logic        stk_ready = 1'b1;
  logic [15:0] stk_addr;
  logic [7:0]  stk_data;
  logic        done;
  logic [15:0] pc_out, sp_out;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  irq_dispatch_unit u0 (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req),
    .cpu_addr_i(cpu_addr), .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata), .ime_set_i(ime_set), .ime_clr_i(ime_clr),
    .ime_o(ime), .step_i(step), .pc_i(pc_in), .sp_i(sp_in),
    .take_o(take), .busy_o(busy), .stk_valid_o(stk_valid),
    .stk_ready_i(stk_ready), .stk_addr_o(stk_addr), .stk_data_o(stk_data),
    .done_o(done), .pc_o(pc_out), .sp_o(sp_out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    tick();
    cpu_wr = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    cpu_addr = a;
    #1;
    check(tag, {8'h00, cpu_rdata}, {8'h00, exp});
  endtask

  task automatic pulse_ime(input logic s, input logic c);
    ime_set = s; ime_clr = c;
    tick();
    ime_set = 1'b0; ime_clr = 1'b0;
  endtask

  // One full dispatch; hold = stalled cycles on the high-byte write.
  task automatic do_dispatch(input string tag, input logic [15:0] pc, input logic [15:0] sp,
                             input logic [15:0] vec, input int hold, input logic [4:0] req_at_step);
    step = 1'b1; pc_in = pc; sp_in = sp; irq_req = req_at_step;
    #1;
    check({tag, " R5 take"}, {15'd0, take}, 16'd1);
    tick();
    step = 1'b0; irq_req = '0;
    stk_ready = (hold == 0);
    #1;
    check({tag, " R8 hi valid"}, {15'd0, stk_valid}, 16'd1);
    check({tag, " R8 hi addr"}, stk_addr, sp - 16'd1);
    check({tag, " R8 hi data"}, {8'h00, stk_data}, {8'h00, pc[15:8]});
    for (int k = 0; k < hold; k++) begin
      tick();
      check({tag, " R9 held valid"}, {15'd0, stk_valid}, 16'd1);
      check({tag, " R9 held addr"}, stk_addr, sp - 16'd1);
      check({tag, " R9 held data"}, {8'h00, stk_data}, {8'h00, pc[15:8]});
    end
    stk_ready = 1'b1;
    tick();
    check({tag, " R8 lo addr"}, stk_addr, sp - 16'd2);
    check({tag, " R8 lo data"}, {8'h00, stk_data}, {8'h00, pc[7:0]});
    check({tag, " R10 no early done"}, {15'd0, done}, 16'd0);
    tick();
    check({tag, " R10 done"}, {15'd0, done}, 16'd1);
    check({tag, " R6 vector"}, pc_out, vec);
    check({tag, " R10 new sp"}, sp_out, sp - 16'd2);
    check({tag, " R10 no write at done"}, {15'd0, stk_valid}, 16'd0);
    tick();
    check({tag, " R10 done one cycle"}, {15'd0, done}, 16'd0);
    check({tag, " R10 idle"}, {15'd0, busy}, 16'd0);
  endtask

  task automatic t_reset();
    check("R1 stk_valid", {15'd0, stk_valid}, 16'd0);
    check("R1 done", {15'd0, done}, 16'd0);
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 ime", {15'd0, ime}, 16'd0);
    read_chk("R1 flag read", 16'hFF0F, 8'hE0);
    read_chk("R1 enable read", 16'hFFFF, 8'h00);
  endtask

  task automatic t_regs();
    cpu_write(16'hFF0F, 8'hFF);
    read_chk("R2 flag all", 16'hFF0F, 8'hFF);
    cpu_write(16'hFF0F, 8'h0A);
    read_chk("R2 flag pattern", 16'hFF0F, 8'hEA);
    cpu_write(16'hFFFF, 8'hFF);
    read_chk("R2 enable all", 16'hFFFF, 8'h1F);
    cpu_write(16'hFFFF, 8'h15);
    read_chk("R2 enable pattern", 16'hFFFF, 8'h15);
    read_chk("R2 other addr", 16'hFF0E, 8'h00);
    cpu_write(16'hFF0F, 8'h00);
    cpu_write(16'hFFFF, 8'h00);
  endtask

  task automatic t_req();
    irq_req = 5'b00100;
    tick();
    irq_req = '0;
    read_chk("R3 request latched", 16'hFF0F, 8'hE4);
    irq_req = 5'b10000;
    cpu_addr = 16'hFF0F; cpu_wdata = 8'h01; cpu_wr = 1'b1;
    tick();
    cpu_wr = 1'b0; irq_req = '0;
    read_chk("R3 request ORed on write", 16'hFF0F, 8'hF1);
    cpu_write(16'hFF0F, 8'h00);
  endtask

  task automatic t_ime();
    pulse_ime(1'b1, 1'b0);
    check("R4 ime set", {15'd0, ime}, 16'd1);
    pulse_ime(1'b0, 1'b1);
    check("R4 ime clear", {15'd0, ime}, 16'd0);
    pulse_ime(1'b1, 1'b0);
    pulse_ime(1'b1, 1'b1);
    check("R4 clear wins", {15'd0, ime}, 16'd0);
  endtask

  task automatic t_no_dispatch();
    cpu_write(16'hFF0F, 8'h01);
    cpu_write(16'hFFFF, 8'h01);
    step = 1'b1; pc_in = 16'h4000; sp_in = 16'hC000;
    #1;
    check("R5 no take without ime", {15'd0, take}, 16'd0);
    tick();
    step = 1'b0;
    check("R5 no write without ime", {15'd0, stk_valid}, 16'd0);
    check("R5 not busy without ime", {15'd0, busy}, 16'd0);
    read_chk("R5 flags kept", 16'hFF0F, 8'hE1);
    cpu_write(16'hFFFF, 8'h00);
    pulse_ime(1'b1, 1'b0);
    step = 1'b1;
    #1;
    check("R5 no take when masked", {15'd0, take}, 16'd0);
    tick();
    step = 1'b0;
    tick();
    check("R5 no write when masked", {15'd0, stk_valid}, 16'd0);
    check("R5 no done when masked", {15'd0, done}, 16'd0);
    read_chk("R5 flags kept masked", 16'hFF0F, 8'hE1);
    check("R5 ime kept", {15'd0, ime}, 16'd1);
    pulse_ime(1'b0, 1'b1);
    cpu_write(16'hFF0F, 8'h00);
  endtask

  task automatic t_priority();
    cpu_write(16'hFFFF, 8'h1F);
    for (int i = 0; i < 5; i++) begin
      logic [4:0] set_bits;
      set_bits = 5'h1F << i;
      cpu_write(16'hFF0F, {3'b000, set_bits});
      pulse_ime(1'b1, 1'b0);
      do_dispatch($sformatf("R6 src%0d", i), 16'h1230 + 16'(i), 16'hD000,
                  16'h0040 + 16'(8 * i), 0, 5'b00000);
      read_chk($sformatf("R7 winner cleared src%0d", i), 16'hFF0F,
               {3'b111, set_bits & ~(5'b1 << i)});
      check($sformatf("R7 ime cleared src%0d", i), {15'd0, ime}, 16'd0);
    end
    cpu_write(16'hFF0F, 8'h00);
  endtask

  task automatic t_stall();
    cpu_write(16'hFF0F, 8'h04);
    pulse_ime(1'b1, 1'b0);
    do_dispatch("R9 stall", 16'hA55A, 16'hCFF0, 16'h0050, 3, 5'b00000);
  endtask

  task automatic t_req_at_clear();
    cpu_write(16'hFF0F, 8'h01);
    pulse_ime(1'b1, 1'b0);
    do_dispatch("R3 race", 16'h0200, 16'hDFFE, 16'h0040, 0, 5'b01000);
    read_chk("R3 request kept during clear", 16'hFF0F, 8'hE8);
    cpu_write(16'hFF0F, 8'h00);
  endtask

  task automatic t_busy();
    int dones;
    cpu_write(16'hFF0F, 8'h03);
    pulse_ime(1'b1, 1'b0);
    step = 1'b1; pc_in = 16'h3333; sp_in = 16'hE000;
    #1;
    check("R10 first take", {15'd0, take}, 16'd1);
    tick();
    step = 1'b0;
    ime_set = 1'b1;
    tick();
    ime_set = 1'b0;
    step = 1'b1;
    #1;
    check("R10 step ignored while busy", {15'd0, take}, 16'd0);
    dones = 0;
    for (int k = 0; k < 6; k++) begin
      tick();
      step = 1'b0;
      if (done) dones++;
    end
    check("R10 single done", 16'(dones), 16'd1);
    check("R10 idle after", {15'd0, busy}, 16'd0);
    read_chk("R10 second source still pending", 16'hFF0F, 8'hE2);
    pulse_ime(1'b0, 1'b1);
    cpu_write(16'hFF0F, 8'h00);
  endtask

  task automatic t_wrap();
    cpu_write(16'hFF0F, 8'h10);
    pulse_ime(1'b1, 1'b0);
    do_dispatch("R11 wrap", 16'hBEEF, 16'h0001, 16'h0060, 0, 5'b00000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_regs();
    t_req();
    t_ime();
    t_no_dispatch();
    t_priority();
    t_stall();
    t_req_at_clear();
    t_busy();
    t_wrap();
    tick();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule